// File: doc/BRIEF.md
# Paged register bank decoder

This block is the address decoder, storage and readback multiplexer of a small memory-mapped register bank on a simple parallel bus. Writes and reads carry separate byte addresses. The block turns the word index of the write address into one write strobe per word, plus a write-ok flag. It turns the read address into read data and a read-ok flag. The bank holds five kinds of storage: a control register, a 64-bit register that spans two consecutive words, a paged register, a write-only register and a narrow 12-bit register. A read-only status word sits on top of these.

The paged register has three physical copies behind one address. The page-select field in the low two bits of the control register picks the copy that reads and writes reach. A select code that has no copy makes the access fail. Reads use two stages. A control-side multiplexer covers the writable registers and returns zero with a failed ok for anything else. A status-side multiplexer serves its own word and otherwise passes the control-side result through. Storage updates on the rising clock edge. A synchronous, active-high reset clears all storage.

Top module: `prb_bank`

## Requirements
- R1: The word index is address bits [4:2]. Bits [1:0] never affect decode, write strobes or read data.
- R2: `wr_strobe` bit i is 1 only while `wr_en` is 1 and the write index equals i for a writable word (indices 0 to 5). At most one bit is set at a time. With `wr_en` low, all bits are 0.
- R3: The 64-bit register occupies indices 1 and 2. Index 1 holds bits [63:32] and index 2 holds bits [31:0]. Each word is written and read back on its own with ok=1.
- R4: The narrow register at index 5 stores `wr_data[11:0]`. It reads back zero-extended to 32 bits with ok=1.
- R5: The write-only register at index 4 appears on `wo_q` one cycle after its strobe. Reading index 4 returns 0 with `rd_ok`=0.
- R6: Index 7 is unmapped. A write there gives `wr_ok`=0 and no strobe. A read gives data 0 and `rd_ok`=0.
- R7: Index 6 reads `stat_in` with `rd_ok`=1. A write there gives `wr_ok`=0 and no strobe. Every other read index returns the control-side result unchanged.
- R8: A write to index 3 raises only `page_wr` bit s, where s is the current page select in control bits [1:0]. Only copy s is updated. A read of index 3 returns copy s with ok=1.
- R9: With page select 3, a write to index 3 gives `wr_ok`=0, `page_wr`=0 and no copy changes. A read of index 3 gives data 0 and ok=0.
- R10: Synchronous reset clears every register, so every mapped read returns 0 and `wo_q` is 0.
- R11: The control register at index 0 stores and reads back all 32 bits, and its bits [1:0] form the page select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request for this cycle |
| wr_addr | input | 5 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read byte address |
| stat_in | input | 32 | Live value of the status word |
| wr_strobe | output | 8 | One write strobe per word index |
| page_wr | output | 3 | Write strobe forwarded to each paged copy |
| wr_ok | output | 1 | Write address is accepted |
| rd_data | output | 32 | Read data |
| rd_ok | output | 1 | Read address is accepted |
| wo_q | output | 32 | Current value of the write-only register |

## Verification
The bench writes distinct values to each copy of the paged register under every valid select. It then reads each copy back, which tells correct copy routing apart from a shared or misrouted copy. The two halves of the wide register get unrelated values, which exposes swapped word order. The bench also reads through nonzero byte offsets, which shows whether the low address bits leak into decode. All-ones writes to the narrow register show whether zero-extension is correct. Writes to the write-only, status and unmapped words, and writes and reads under select 3, tell a failed access apart from a silent fallthrough to a neighbouring register.

// File: rtl/prb_pkg.sv
package prb_pkg;

  typedef enum logic [2:0] {
    RK_CTRL,
    RK_WIDE,
    RK_PAGE,
    RK_WO,
    RK_NARROW,
    RK_STAT,
    RK_NONE
  } reg_kind_e;

  // First word index of each register kind; the wide register spans wide_nw words.
  function automatic int unsigned kind_base(reg_kind_e k, int unsigned wide_nw);
    case (k)
      RK_CTRL:   return 0;
      RK_WIDE:   return 1;
      RK_PAGE:   return 1 + wide_nw;
      RK_WO:     return 2 + wide_nw;
      RK_NARROW: return 3 + wide_nw;
      RK_STAT:   return 4 + wide_nw;
      default:   return 0;
    endcase
  endfunction

  function automatic reg_kind_e idx_kind(int unsigned idx, int unsigned wide_nw);
    if (idx == kind_base(RK_CTRL, wide_nw))   return RK_CTRL;
    if (idx >= kind_base(RK_WIDE, wide_nw) && idx < kind_base(RK_PAGE, wide_nw))
                                              return RK_WIDE;
    if (idx == kind_base(RK_PAGE, wide_nw))   return RK_PAGE;
    if (idx == kind_base(RK_WO, wide_nw))     return RK_WO;
    if (idx == kind_base(RK_NARROW, wide_nw)) return RK_NARROW;
    if (idx == kind_base(RK_STAT, wide_nw))   return RK_STAT;
    return RK_NONE;
  endfunction

  function automatic logic kind_writable(reg_kind_e k);
    return (k == RK_CTRL) || (k == RK_WIDE) || (k == RK_PAGE) ||
           (k == RK_WO) || (k == RK_NARROW);
  endfunction

  // Bit offset of word k inside a multi-word register, most significant word first.
  function automatic int unsigned word_shift(int unsigned k, int unsigned nw,
                                             int unsigned ww);
    return (nw - 1 - k) * ww;
  endfunction

endpackage

// File: rtl/prb_wr_decode.sv
module prb_wr_decode
  import prb_pkg::*;
#(
  parameter int IDX_W   = 3,
  parameter int WIDE_NW = 2
) (
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic                    sel_valid,
  output logic [(1<<IDX_W)-1:0]   word_strobe,
  output logic                    addr_ok
);
  localparam int NWORDS   = 1 << IDX_W;
  localparam int PAGE_IDX = int'(kind_base(RK_PAGE, WIDE_NW));

  reg_kind_e wr_kind;
  assign wr_kind = idx_kind(int'(wr_idx), WIDE_NW);

  for (genvar i = 0; i < NWORDS; i++) begin : g_strobe
    localparam logic WRITABLE = kind_writable(idx_kind(i, WIDE_NW));
    assign word_strobe[i] = wr_en && WRITABLE && (int'(wr_idx) == i);
  end

  always_comb begin
    addr_ok = kind_writable(wr_kind);
    if (int'(wr_idx) == PAGE_IDX && !sel_valid) addr_ok = 1'b0;
  end
endmodule

// File: rtl/prb_page_route.sv
module prb_page_route #(
  parameter int COPIES = 3,
  parameter int SEL_W  = 2
) (
  input  logic              page_strobe,
  input  logic [SEL_W-1:0]  sel,
  output logic [COPIES-1:0] copy_wr,
  output logic              sel_valid
);
  assign sel_valid = int'(sel) < COPIES;

  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    assign copy_wr[c] = page_strobe && (int'(sel) == c);
  end
endmodule

// File: rtl/prb_ctrl_rdmux.sv
module prb_ctrl_rdmux
  import prb_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int IDX_W    = 3,
  parameter int WIDE_NW  = 2,
  parameter int NARROW_W = 12,
  parameter int COPIES   = 3,
  parameter int SEL_W    = 2
) (
  input  logic [IDX_W-1:0]           idx,
  input  logic [WORD_W-1:0]          ctrl_q,
  input  logic [WIDE_NW*WORD_W-1:0]  wide_q,
  input  logic [COPIES*WORD_W-1:0]   page_q,
  input  logic [SEL_W-1:0]           sel,
  input  logic [NARROW_W-1:0]        nar_q,
  output logic [WORD_W-1:0]          data,
  output logic                       ok
);
  localparam int WIDE_BASE = int'(kind_base(RK_WIDE, WIDE_NW));

  logic [WORD_W-1:0] wide_w [WIDE_NW];
  logic [WORD_W-1:0] page_w [COPIES];

  for (genvar k = 0; k < WIDE_NW; k++) begin : g_wide
    assign wide_w[k] = wide_q[word_shift(k, WIDE_NW, WORD_W) +: WORD_W];
  end
  for (genvar c = 0; c < COPIES; c++) begin : g_page
    assign page_w[c] = page_q[c*WORD_W +: WORD_W];
  end

  reg_kind_e kind;
  assign kind = idx_kind(int'(idx), WIDE_NW);

  always_comb begin
    data = '0;
    ok   = 1'b0;
    case (kind)
      RK_CTRL: begin
        data = ctrl_q;
        ok   = 1'b1;
      end
      RK_WIDE: begin
        for (int k = 0; k < WIDE_NW; k++)
          if (int'(idx) == WIDE_BASE + k) data = wide_w[k];
        ok = 1'b1;
      end
      RK_PAGE: begin
        for (int c = 0; c < COPIES; c++)
          if (int'(sel) == c) begin
            data = page_w[c];
            ok   = 1'b1;
          end
      end
      RK_NARROW: begin
        data = {{(WORD_W-NARROW_W){1'b0}}, nar_q};
        ok   = 1'b1;
      end
      default: begin
        data = '0;
        ok   = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/prb_stat_rdmux.sv
module prb_stat_rdmux
  import prb_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int IDX_W   = 3,
  parameter int WIDE_NW = 2
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] stat_in,
  input  logic [WORD_W-1:0] fb_data,
  input  logic              fb_ok,
  output logic [WORD_W-1:0] data,
  output logic              ok
);
  always_comb begin
    if (idx_kind(int'(idx), WIDE_NW) == RK_STAT) begin
      data = stat_in;
      ok   = 1'b1;
    end else begin
      data = fb_data;
      ok   = fb_ok;
    end
  end
endmodule

// File: rtl/prb_bank.sv
module prb_bank
  import prb_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int BANK_BYTES  = 32,
  parameter int WIDE_W      = 64,
  parameter int NARROW_W    = 12,
  parameter int PAGE_COPIES = 3,
  parameter int SEL_W       = 2,
  localparam int OFF_BITS   = $clog2(WORD_W/8),
  localparam int ADDR_W     = $clog2(BANK_BYTES),
  localparam int IDX_W      = ADDR_W - OFF_BITS,
  localparam int NWORDS     = 1 << IDX_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [WORD_W-1:0]      wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic [WORD_W-1:0]      stat_in,
  output logic [NWORDS-1:0]      wr_strobe,
  output logic [PAGE_COPIES-1:0] page_wr,
  output logic                   wr_ok,
  output logic [WORD_W-1:0]      rd_data,
  output logic                   rd_ok,
  output logic [WORD_W-1:0]      wo_q
);
  localparam int WIDE_NW   = WIDE_W / WORD_W;
  localparam int CTRL_IDX  = int'(kind_base(RK_CTRL, WIDE_NW));
  localparam int WIDE_BASE = int'(kind_base(RK_WIDE, WIDE_NW));
  localparam int PAGE_IDX  = int'(kind_base(RK_PAGE, WIDE_NW));
  localparam int WO_IDX    = int'(kind_base(RK_WO, WIDE_NW));
  localparam int NAR_IDX   = int'(kind_base(RK_NARROW, WIDE_NW));

  logic [IDX_W-1:0] wr_idx, rd_idx;
  assign wr_idx = wr_addr[ADDR_W-1:OFF_BITS];
  assign rd_idx = rd_addr[ADDR_W-1:OFF_BITS];

  logic [WORD_W-1:0]             ctrl_q;
  logic [WIDE_W-1:0]             wide_q;
  logic [PAGE_COPIES*WORD_W-1:0] page_q;
  logic [WORD_W-1:0]             wo_r;
  logic [NARROW_W-1:0]           nar_q;

  logic [SEL_W-1:0] page_sel;
  logic             sel_valid;
  assign page_sel = ctrl_q[SEL_W-1:0];

  prb_wr_decode #(.IDX_W(IDX_W), .WIDE_NW(WIDE_NW)) u_wdec (
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .sel_valid  (sel_valid),
    .word_strobe(wr_strobe),
    .addr_ok    (wr_ok)
  );

  prb_page_route #(.COPIES(PAGE_COPIES), .SEL_W(SEL_W)) u_page (
    .page_strobe(wr_strobe[PAGE_IDX]),
    .sel        (page_sel),
    .copy_wr    (page_wr),
    .sel_valid  (sel_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      wide_q <= '0;
      page_q <= '0;
      wo_r   <= '0;
      nar_q  <= '0;
    end else begin
      if (wr_strobe[CTRL_IDX]) ctrl_q <= wr_data;
      for (int k = 0; k < WIDE_NW; k++)
        if (wr_strobe[WIDE_BASE + k])
          wide_q[word_shift(k, WIDE_NW, WORD_W) +: WORD_W] <= wr_data;
      for (int c = 0; c < PAGE_COPIES; c++)
        if (page_wr[c]) page_q[c*WORD_W +: WORD_W] <= wr_data;
      if (wr_strobe[WO_IDX])  wo_r  <= wr_data;
      if (wr_strobe[NAR_IDX]) nar_q <= wr_data[NARROW_W-1:0];
    end
  end

  assign wo_q = wo_r;

  logic [WORD_W-1:0] ctrl_rd_data;
  logic              ctrl_rd_ok;

  prb_ctrl_rdmux #(
    .WORD_W(WORD_W), .IDX_W(IDX_W), .WIDE_NW(WIDE_NW),
    .NARROW_W(NARROW_W), .COPIES(PAGE_COPIES), .SEL_W(SEL_W)
  ) u_crd (
    .idx   (rd_idx),
    .ctrl_q(ctrl_q),
    .wide_q(wide_q),
    .page_q(page_q),
    .sel   (page_sel),
    .nar_q (nar_q),
    .data  (ctrl_rd_data),
    .ok    (ctrl_rd_ok)
  );

  prb_stat_rdmux #(.WORD_W(WORD_W), .IDX_W(IDX_W), .WIDE_NW(WIDE_NW)) u_srd (
    .idx    (rd_idx),
    .stat_in(stat_in),
    .fb_data(ctrl_rd_data),
    .fb_ok  (ctrl_rd_ok),
    .data   (rd_data),
    .ok     (rd_ok)
  );
endmodule

// File: rtl/prb_bank_chk.sv
module prb_bank_chk #(
  parameter int WORD_W   = 32,
  parameter int ADDR_W   = 5,
  parameter int OFF_BITS = 2,
  parameter int NWORDS   = 8,
  parameter int COPIES   = 3,
  parameter int SEL_W    = 2,
  parameter int PAGE_IDX = 3,
  parameter int WO_IDX   = 4,
  parameter int STAT_IDX = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [WORD_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [WORD_W-1:0] stat_in,
  input logic [NWORDS-1:0] wr_strobe,
  input logic [COPIES-1:0] page_wr,
  input logic              wr_ok,
  input logic [WORD_W-1:0] rd_data,
  input logic              rd_ok,
  input logic [WORD_W-1:0] wo_q,
  input logic [SEL_W-1:0]  page_sel
);
  logic [ADDR_W-OFF_BITS-1:0] wi, ri;
  assign wi = wr_addr[ADDR_W-1:OFF_BITS];
  assign ri = rd_addr[ADDR_W-1:OFF_BITS];

  p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_strobe));
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> wr_strobe == '0);
  p_page_single_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(page_wr));
  p_page_needs_word_r8: assert property (@(posedge clk) disable iff (rst)
    (page_wr != '0) |-> wr_strobe[PAGE_IDX]);
  p_bad_sel_no_copy_r9: assert property (@(posedge clk) disable iff (rst)
    (int'(page_sel) >= COPIES) |-> page_wr == '0);
  p_bad_sel_wrok_r9: assert property (@(posedge clk) disable iff (rst)
    (int'(page_sel) >= COPIES && int'(wi) == PAGE_IDX) |-> !wr_ok);
  p_wo_read_r5: assert property (@(posedge clk) disable iff (rst)
    (int'(ri) == WO_IDX) |-> (rd_data == '0 && !rd_ok));
  p_wo_capture_r5: assert property (@(posedge clk) disable iff (rst)
    wr_strobe[WO_IDX] |=> wo_q == $past(wr_data));
  p_unmapped_read_r6: assert property (@(posedge clk) disable iff (rst)
    (int'(ri) == NWORDS - 1) |-> (rd_data == '0 && !rd_ok));
  p_status_read_r7: assert property (@(posedge clk) disable iff (rst)
    (int'(ri) == STAT_IDX) |-> (rd_data == stat_in && rd_ok));
endmodule

bind prb_bank prb_bank_chk #(
  .WORD_W(WORD_W), .ADDR_W(ADDR_W), .OFF_BITS(OFF_BITS), .NWORDS(NWORDS),
  .COPIES(PAGE_COPIES), .SEL_W(SEL_W), .PAGE_IDX(PAGE_IDX), .WO_IDX(WO_IDX),
  .STAT_IDX(int'(prb_pkg::kind_base(prb_pkg::RK_STAT, WIDE_NW)))
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .stat_in(stat_in), .wr_strobe(wr_strobe),
  .page_wr(page_wr), .wr_ok(wr_ok), .rd_data(rd_data), .rd_ok(rd_ok),
  .wo_q(wo_q), .page_sel(page_sel)
);

// File: tb/prb_bank_test.sv
module prb_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] stat_in = '0;
  logic [7:0]  wr_strobe;
  logic [2:0]  page_wr;
  logic        wr_ok;
  logic [31:0] rd_data;
  logic        rd_ok;
  logic [31:0] wo_q;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // reference model
  logic [31:0] m_ctrl, m_hi, m_lo, m_wo;
  logic [31:0] m_page [3];
  logic [11:0] m_nar;

  always #5 clk = ~clk;

  prb_bank uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .stat_in(stat_in), .wr_strobe(wr_strobe),
    .page_wr(page_wr), .wr_ok(wr_ok), .rd_data(rd_data), .rd_ok(rd_ok),
    .wo_q(wo_q)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic model_clear();
    m_ctrl = '0; m_hi = '0; m_lo = '0; m_wo = '0; m_nar = '0;
    for (int c = 0; c < 3; c++) m_page[c] = '0;
  endtask

  task automatic model_read(input int idx, output logic [31:0] d, output logic ok);
    d = '0; ok = 1'b0;
    case (idx)
      0: begin d = m_ctrl; ok = 1'b1; end
      1: begin d = m_hi;   ok = 1'b1; end
      2: begin d = m_lo;   ok = 1'b1; end
      3: if (m_ctrl[1:0] != 2'd3) begin d = m_page[m_ctrl[1:0]]; ok = 1'b1; end
      5: begin d = {20'd0, m_nar}; ok = 1'b1; end
      6: begin d = stat_in; ok = 1'b1; end
      default: begin d = '0; ok = 1'b0; end
    endcase
  endtask

  task automatic do_write(input logic [4:0] a, input logic [31:0] d, input string tag);
    int idx = int'(a >> 2);
    logic [1:0] sel = m_ctrl[1:0];
    logic wrt = (idx <= 5);
    logic pg  = (idx == 3);
    logic eok = wrt && !(pg && sel == 2'd3);
    logic [7:0] estb = wrt ? (8'b1 << idx) : 8'b0;
    logic [2:0] epw = (pg && sel != 2'd3) ? (3'b1 << sel) : 3'b0;
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    #1;
    chk({tag, " wr_ok"}, {31'd0, wr_ok}, {31'd0, eok});
    chk({tag, " wr_strobe"}, {24'd0, wr_strobe}, {24'd0, estb});
    chk({tag, " page_wr"}, {29'd0, page_wr}, {29'd0, epw});
    @(posedge clk);
    case (idx)
      0: m_ctrl = d;
      1: m_hi = d;
      2: m_lo = d;
      3: if (sel != 2'd3) m_page[sel] = d;
      4: m_wo = d;
      5: m_nar = d[11:0];
      default: ;
    endcase
    #1;
    wr_en = 1'b0;
    chk({tag, " wo_q"}, wo_q, m_wo);
  endtask

  task automatic do_read(input logic [4:0] a, input string tag);
    logic [31:0] ed;
    logic eo;
    @(negedge clk);
    rd_addr = a;
    #1;
    model_read(int'(a >> 2), ed, eo);
    chk({tag, " rd_data"}, rd_data, ed);
    chk({tag, " rd_ok"}, {31'd0, rd_ok}, {31'd0, eo});
  endtask

  task automatic t_reset_r10();
    for (int a = 0; a < 32; a += 4) do_read(5'(a), "R10 reset read");
    chk("R10 reset wo_q", wo_q, 32'd0);
  endtask

  task automatic t_ctrl_r11();
    do_write(5'd0, 32'hA5A5_5A58, "R11 ctrl write");
    do_read(5'd0, "R11 ctrl read");
    do_read(5'd3, "R1 ctrl via byte offset");
  endtask

  task automatic t_wide_r3();
    do_write(5'd4, 32'h1122_3344, "R3 wide upper");
    do_write(5'd9, 32'h5566_7788, "R3 wide lower via offset R1");
    do_read(5'd4, "R3 wide upper");
    do_read(5'd8, "R3 wide lower");
    do_read(5'd6, "R1 wide upper via offset");
    do_write(5'd8, 32'h0BAD_F00D, "R3 lower only");
    do_read(5'd4, "R3 upper unchanged");
    do_read(5'd8, "R3 lower updated");
  endtask

  task automatic t_narrow_r4();
    do_write(5'd20, 32'hFFFF_FFFF, "R4 narrow all ones");
    do_read(5'd20, "R4 narrow zero-extend");
    do_write(5'd20, 32'h1234_5ABC, "R4 narrow pattern");
    do_read(5'd22, "R4 narrow readback");
  endtask

  task automatic t_wo_r5();
    do_write(5'd16, 32'hDEAD_BEEF, "R5 wo write");
    do_read(5'd16, "R5 wo read");
    chk("R5 wo_q", wo_q, 32'hDEAD_BEEF);
  endtask

  task automatic t_unmapped_r6();
    do_write(5'd28, 32'hFFFF_FFFF, "R6 unmapped write");
    do_read(5'd28, "R6 unmapped read");
    do_read(5'd31, "R6 unmapped offset read");
  endtask

  task automatic t_status_r7();
    stat_in = 32'h1357_9BDF;
    do_read(5'd24, "R7 status read");
    do_write(5'd24, 32'h0000_0001, "R7 status write");
    stat_in = 32'h2468_ACE0;
    do_read(5'd24, "R7 status live");
    do_read(5'd0, "R7 fallback ctrl");
  endtask

  task automatic t_page_r8();
    for (int s = 0; s < 3; s++) begin
      do_write(5'd0, 32'hC000_0000 | 32'(s), "R8 set select");
      do_write(5'd12, 32'h7000_0000 + 32'(s * 32'h0101_0101), "R8 page write");
    end
    for (int s = 2; s >= 0; s--) begin
      do_write(5'd0, 32'(s), "R8 set select");
      do_read(5'd12, "R8 page read");
    end
  endtask

  task automatic t_bad_sel_r9();
    do_write(5'd0, 32'h0000_0003, "R9 select 3");
    do_write(5'd12, 32'hFFFF_0000, "R9 write rejected");
    do_read(5'd12, "R9 read rejected");
    do_write(5'd0, 32'h0000_0001, "R9 back to 1");
    do_read(5'd12, "R9 copy 1 unchanged");
    do_write(5'd0, 32'h0000_0000, "R9 back to 0");
    do_read(5'd12, "R9 copy 0 unchanged");
  endtask

  task automatic t_idle_r2();
    @(negedge clk);
    wr_addr = 5'd0; wr_data = 32'hFFFF_FFFF; wr_en = 1'b0;
    #1;
    chk("R2 idle strobe", {24'd0, wr_strobe}, 32'd0);
    chk("R2 idle page_wr", {29'd0, page_wr}, 32'd0);
    @(posedge clk);
    do_read(5'd0, "R2 idle no change");
  endtask

  task automatic t_midreset_r10();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_clear();
    stat_in = '0;
    t_reset_r10();
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_r10();
    t_ctrl_r11();
    t_wide_r3();
    t_narrow_r4();
    t_wo_r5();
    t_unmapped_r6();
    t_status_r7();
    t_page_r8();
    t_bad_sel_r9();
    t_idle_r2();
    t_midreset_r10();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule